// File: doc/BRIEF.md
# Constant-Time Modular Exponentiation Engine

This unit raises a base to an exponent modulo a modulus for a parameterised operand width `W`. It scans the exponent from the most significant bit down to the least. For each bit it squares the accumulator, then multiplies by the base when the bit is set. All modular products come from one bit-serial multiplier that interleaves shifting, adding and reducing. Before the scan, the base is reduced modulo the modulus by one pass through the same multiplier.

A host places the operands on the inputs and pulses `start_i`. It then waits for the one-cycle `done_o` pulse, which comes with the result. The `ct_en_i` bit is sampled together with the operands, and a driver sets it for private-key work. With it set, every cleared exponent bit still runs a multiply of the same length, and that product is dropped. The run time then depends on `W` alone. With it clear, cleared bits skip the multiply, so the run time follows the number of set exponent bits.

Top module: `mx_modexp`

## Requirements
- R1: When `start_i` is high while `busy_o` is low, the engine samples `base_i`, `exp_i`, `mod_i` and `ct_en_i`. It later returns `base_i ^ exp_i mod mod_i` on `result_o` for any base value and any non-zero modulus, including a base not smaller than the modulus.
- R2: `done_o` is high for exactly one cycle per accepted start, and `result_o` keeps its value in every cycle in which `done_o` is low.
- R3: After reset, `busy_o` and `done_o` are low and `result_o` is zero. `busy_o` is high from the cycle after an accepted start up to the cycle before `done_o`, and it is low in the `done_o` cycle.
- R4: A `start_i` pulse while `busy_o` is high is ignored: the running operation's result and latency are unchanged, and no extra `done_o` follows.
- R5: With the sampled `ct_en_i` at 1, `done_o` rises exactly `(2W+1)*(W+2)+1` cycles after the start cycle, whatever the operand values.
- R6: With the sampled `ct_en_i` at 0, `done_o` rises exactly `(W+1+k)*(W+2)+1` cycles after the start cycle, where `k` is the number of set bits in the exponent.
- R7: In constant-time mode the product of a cleared bit's multiply is discarded, so the result equals the result with the mode off.
- R8: An exponent of zero returns 1 for any modulus above 1, and a modulus of 1 returns 0 for any base and exponent.
- R9: Every returned result is smaller than the sampled modulus.
- R10: Changes on `ct_en_i` or the operand inputs after the start cycle have no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| ct_en_i | input | 1 | Constant-time mode select, sampled with start |
| base_i | input | W | Base operand |
| exp_i | input | W | Exponent operand |
| mod_i | input | W | Modulus, must be non-zero |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Result, held until the next completion |

## Verification
The checker assumes a non-zero modulus sampled at each accepted start. The multiplier's reduction and the result-below-modulus property both rely on that. Its latency counter measures from the accepted start to the completion pulse, so it also assumes that start is seen as a level only in the cycle it is meant for. The stimulus always uses a modulus of at least 1, including the modulus-1 corner. It drives start as a single-cycle pulse, and the deliberately ignored pulse comes only while the engine reports busy.

// File: rtl/mx_pkg.sv
package mx_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_PREP   = 2'd1,
        SQ_SQUARE = 2'd2,
        SQ_MULT   = 2'd3
    } seq_state_e;

endpackage

// File: rtl/mx_modmul.sv
// Bit-serial interleaved modular multiplier: prod = mcand * mplier mod modv.
// A start is taken when idle; done pulses W+1 cycles after the start cycle.
// Requires mcand < modv (or modv == 1) and modv != 0; mplier may be any value.
module mx_modmul #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] m_i,
    output logic         done_o,
    output logic [W-1:0] prod_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  acc;
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic [W-1:0]  modv;
        logic [CW-1:0] left;
        logic          run;
        logic          fin;
    } mm_t;

    mm_t mm_d, mm_q;

    logic [W:0]   dbl;
    logic [W:0]   dbl_red;
    logic [W:0]   sum;
    logic [W-1:0] sum_red;

    always_comb begin
        mm_d     = mm_q;
        mm_d.fin = 1'b0;

        // one interleaved step: acc = (2*acc + bit*mcand) mod modv
        dbl     = {mm_q.acc, 1'b0};
        dbl_red = (dbl >= {1'b0, mm_q.modv}) ? (dbl - {1'b0, mm_q.modv}) : dbl;
        sum     = dbl_red + (mm_q.mplier[W-1] ? {1'b0, mm_q.mcand} : '0);
        sum_red = (sum >= {1'b0, mm_q.modv}) ? W'(sum - {1'b0, mm_q.modv}) : W'(sum);

        if (start_i && !mm_q.run) begin
            mm_d.acc    = '0;
            mm_d.mcand  = a_i;
            mm_d.mplier = b_i;
            mm_d.modv   = m_i;
            mm_d.left   = CW'(W);
            mm_d.run    = 1'b1;
        end else if (mm_q.run) begin
            mm_d.acc    = sum_red;
            mm_d.mplier = mm_q.mplier << 1;
            mm_d.left   = mm_q.left - CW'(1);
            if (mm_q.left == CW'(1)) begin
                mm_d.run = 1'b0;
                mm_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mm_q <= '0;
        else        mm_q <= mm_d;
    end

    assign done_o = mm_q.fin;
    assign prod_o = mm_q.acc;

endmodule

// File: rtl/mx_seq.sv
// Exponent sequencer: pre-reduces the base, then per exponent bit (MSB first)
// issues a square and, if the bit is set or constant-time mode is on, a
// multiply. A cleared bit's multiply result is never written to the accumulator.
module mx_seq
    import mx_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ct_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    input  logic         mm_done_i,
    input  logic [W-1:0] mm_prod_i,
    output logic         mm_go_o,
    output logic [W-1:0] mm_a_o,
    output logic [W-1:0] mm_b_o,
    output logic [W-1:0] mm_m_o,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [W-1:0]  base;
        logic [W-1:0]  expo;
        logic [W-1:0]  modv;
        logic [W-1:0]  acc;
        logic [CW-1:0] left;
        logic          ct;
        logic          go;
        logic          busy;
        logic          fin;
        logic [W-1:0]  res;
    } sq_t;

    sq_t sq_d, sq_q;

    logic         advance;
    logic [W-1:0] acc_now;

    always_comb begin
        sq_d     = sq_q;
        sq_d.go  = 1'b0;
        sq_d.fin = 1'b0;
        advance  = 1'b0;
        acc_now  = sq_q.acc;

        unique case (sq_q.state)
            SQ_IDLE: begin
                if (start_i) begin
                    sq_d.base  = base_i;
                    sq_d.expo  = exp_i;
                    sq_d.modv  = mod_i;
                    sq_d.ct    = ct_i;
                    sq_d.acc   = (mod_i == W'(1)) ? '0 : W'(1);
                    sq_d.left  = CW'(W);
                    sq_d.state = SQ_PREP;
                    sq_d.go    = 1'b1;
                    sq_d.busy  = 1'b1;
                end
            end
            SQ_PREP: begin
                if (mm_done_i) begin
                    sq_d.base  = mm_prod_i;
                    sq_d.state = SQ_SQUARE;
                    sq_d.go    = 1'b1;
                end
            end
            SQ_SQUARE: begin
                if (mm_done_i) begin
                    sq_d.acc = mm_prod_i;
                    acc_now  = mm_prod_i;
                    if (sq_q.expo[W-1] || sq_q.ct) begin
                        sq_d.state = SQ_MULT;
                        sq_d.go    = 1'b1;
                    end else begin
                        advance = 1'b1;
                    end
                end
            end
            SQ_MULT: begin
                if (mm_done_i) begin
                    // dummy product (cleared bit) is dropped here
                    if (sq_q.expo[W-1]) begin
                        sq_d.acc = mm_prod_i;
                        acc_now  = mm_prod_i;
                    end
                    advance = 1'b1;
                end
            end
            default: sq_d.state = SQ_IDLE;
        endcase

        if (advance) begin
            sq_d.expo = sq_q.expo << 1;
            sq_d.left = sq_q.left - CW'(1);
            if (sq_q.left == CW'(1)) begin
                sq_d.state = SQ_IDLE;
                sq_d.busy  = 1'b0;
                sq_d.fin   = 1'b1;
                sq_d.res   = acc_now;
            end else begin
                sq_d.state = SQ_SQUARE;
                sq_d.go    = 1'b1;
            end
        end
    end

    always_comb begin
        unique case (sq_q.state)
            SQ_PREP: begin
                mm_a_o = W'(1);
                mm_b_o = sq_q.base;
            end
            SQ_MULT: begin
                mm_a_o = sq_q.base;
                mm_b_o = sq_q.acc;
            end
            default: begin
                mm_a_o = sq_q.acc;
                mm_b_o = sq_q.acc;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign mm_go_o  = sq_q.go;
    assign mm_m_o   = sq_q.modv;
    assign busy_o   = sq_q.busy;
    assign done_o   = sq_q.fin;
    assign result_o = sq_q.res;

endmodule

// File: rtl/mx_modexp.sv
module mx_modexp #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         ct_en_i,
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] exp_i,
    input  logic [W-1:0] mod_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);
    logic         mm_go;
    logic         mm_done;
    logic [W-1:0] mm_a;
    logic [W-1:0] mm_b;
    logic [W-1:0] mm_m;
    logic [W-1:0] mm_prod;

    mx_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .ct_i      (ct_en_i),
        .base_i    (base_i),
        .exp_i     (exp_i),
        .mod_i     (mod_i),
        .mm_done_i (mm_done),
        .mm_prod_i (mm_prod),
        .mm_go_o   (mm_go),
        .mm_a_o    (mm_a),
        .mm_b_o    (mm_b),
        .mm_m_o    (mm_m),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .result_o  (result_o)
    );

    mx_modmul #(.W(W)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (mm_go),
        .a_i     (mm_a),
        .b_i     (mm_b),
        .m_i     (mm_m),
        .done_o  (mm_done),
        .prod_o  (mm_prod)
    );

endmodule

// File: rtl/mx_check.sv
module mx_check #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         ct_en_i,
    input logic [W-1:0] mod_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] result_o
);
    localparam int STEP     = W + 2;
    localparam int CT_BUSY  = (2 * W + 1) * STEP;
    localparam int MIN_BUSY = (W + 1) * STEP;

    logic [31:0]  busy_cnt;
    logic         ct_l;
    logic [W-1:0] mod_l;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            ct_l     <= 1'b0;
            mod_l    <= '0;
        end else if (start_i && !busy_o) begin
            busy_cnt <= '0;
            ct_l     <= ct_en_i;
            mod_l    <= mod_i;
        end else if (busy_o) begin
            busy_cnt <= busy_cnt + 32'd1;
        end
    end

    a_r2_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r2_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r3_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r3_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r5_ct_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && ct_l) |-> (busy_cnt == 32'(CT_BUSY)));

    a_r6_var_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !ct_l) |-> (busy_cnt >= 32'(MIN_BUSY) && busy_cnt <= 32'(CT_BUSY)));

    a_r8_unit_modulus: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mod_l == W'(1)) |-> (result_o == '0));

    a_r9_reduced: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (result_o < mod_l));

endmodule

bind mx_modexp mx_check #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .ct_en_i  (ct_en_i),
    .mod_i    (mod_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/tb_mx_modexp.sv
`timescale 1ns/1ps
module tb_mx_modexp;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         ct_en_i = 1'b0;
    logic [W-1:0] base_i = '0;
    logic [W-1:0] exp_i = '0;
    logic [W-1:0] mod_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [W-1:0] result_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    mx_modexp #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ct_en_i(ct_en_i),
        .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic logic [63:0] ref_pow(input logic [W-1:0] b, input logic [W-1:0] e, input logic [W-1:0] m);
        logic [63:0] r, bb, mm;
        mm = {32'd0, m};
        r  = 64'd1 % mm;
        bb = {32'd0, b} % mm;
        for (int i = W - 1; i >= 0; i--) begin
            r = (r * r) % mm;
            if (e[i]) r = (r * bb) % mm;
        end
        return r;
    endfunction

    // Runs one operation; intr > 0 injects a start pulse with other operands
    // and a flipped mode bit in that cycle of the run.
    task automatic run_op(input logic [W-1:0] b, input logic [W-1:0] e, input logic [W-1:0] m,
                          input bit ct, input int intr, input string tag);
        int n;
        int lat;
        logic [63:0] want;
        want = ref_pow(b, e, m);
        lat  = ct ? ((2 * W + 1) * (W + 2) + 1) : ((W + 1 + $countones(e)) * (W + 2) + 1);
        @(negedge clk);
        base_i = b; exp_i = e; mod_i = m; ct_en_i = ct; start_i = 1'b1;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                start_i = 1'b0;
                base_i = ~b; exp_i = ~e; ct_en_i = ~ct; // R10: later input changes
                chk(busy_o === 1'b1, "R3 busy after start", {63'd0, busy_o}, 64'd1);
            end
            if (intr > 0 && n == intr) begin
                start_i = 1'b1; mod_i = m ^ 32'h5A5A_0001; // R4: start while busy
            end
            if (intr > 0 && n == intr + 1) start_i = 1'b0;
            if (done_o === 1'b1 || n > 4000) break;
        end
        chk(result_o === want[W-1:0], {tag, " result"}, {32'd0, result_o}, want);
        chk(n == lat, ct ? "R5 latency" : "R6 latency", n, lat);
        chk(busy_o === 1'b0, "R3 idle at done", {63'd0, busy_o}, 64'd0);
        chk({32'd0, result_o} < {32'd0, m}, "R9 result below modulus", {32'd0, result_o}, {32'd0, m});
        @(negedge clk);
        chk(done_o === 1'b0, "R2 done single pulse", {63'd0, done_o}, 64'd0);
        chk(result_o === want[W-1:0], "R2 result held", {32'd0, result_o}, want);
    endtask

    task automatic t_reset;
        chk(busy_o === 1'b0, "R3 reset busy", {63'd0, busy_o}, 64'd0);
        chk(done_o === 1'b0, "R3 reset done", {63'd0, done_o}, 64'd0);
        chk(result_o === '0, "R3 reset result", {32'd0, result_o}, 64'd0);
    endtask

    task automatic t_plain;
        run_op(32'h0000_1234, 32'h0001_0001, 32'hF123_4567, 1'b0, 0, "R1 plain a");
        run_op(32'd7, 32'd1_000_000_005, 32'd1_000_000_007, 1'b0, 0, "R1 plain b");
        run_op(32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 1'b0, 0, "R1 plain c");
        run_op(32'd3, 32'h8000_0000, 32'd97, 1'b0, 0, "R6 single top bit");
    endtask

    task automatic t_const;
        run_op(32'h0000_1234, 32'h0001_0001, 32'hF123_4567, 1'b1, 0, "R7 ct a");
        run_op(32'hDEAD_BEEF, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 1'b1, 0, "R7 ct all ones");
        run_op(32'd5, 32'd0, 32'd1009, 1'b1, 0, "R5 ct zero exponent");
        run_op(32'd3, 32'h8000_0000, 32'd97, 1'b1, 0, "R7 ct single top bit");
    endtask

    task automatic t_edges;
        run_op(32'd123, 32'd0, 32'd1000, 1'b0, 0, "R8 zero exponent");
        run_op(32'd99, 32'd12345, 32'd1, 1'b0, 0, "R8 unit modulus");
        run_op(32'd99, 32'd0, 32'd1, 1'b1, 0, "R8 unit modulus zero exp");
        run_op(32'hFFFF_FFFF, 32'd65537, 32'd1_000_003, 1'b0, 0, "R1 base above modulus");
        run_op(32'd0, 32'd17, 32'd65521, 1'b1, 0, "R1 zero base");
    endtask

    task automatic t_busy_ignore;
        run_op(32'd2, 32'h00F0_0F0F, 32'd4093, 1'b0, 300, "R4 ignored start plain");
        run_op(32'd2, 32'h00F0_0F0F, 32'd4093, 1'b1, 900, "R4 ignored start ct");
        for (int i = 0; i < W + 8; i++) begin
            @(negedge clk);
            if (done_o !== 1'b0 || busy_o !== 1'b0) break;
        end
        chk(done_o === 1'b0 && busy_o === 1'b0, "R4 no extra operation",
            {62'd0, done_o, busy_o}, 64'd0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_plain();
        t_const();
        t_edges();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule